// File: doc/BRIEF.md
# Lockstep Neuron Network Step Sequencer

This block is the control unit of a pipelined network simulator in which every neuron advances one simulation step in lockstep with all others. It owns no arithmetic. It keeps nested counters for the coupling-loop tick, the neuron being evaluated and the number of completed steps. From those counters it requests initial states, connection-weight batches and evoked inputs over valid/ready streams, and it strobes the on-chip state memory. It also gates the valid signal that enters the dendrite pipeline and returns a done flag when the configured number of steps has finished.

A run begins with a single-cycle `start` pulse. The block latches the network size, step total, coupling mode and unroll factor, then loads one initial state word per neuron. With coupling enabled, each neuron first spends ceil(N/U) loop ticks collecting weight batches while the dendrite output is held invalid, and then evaluates in one tick. The pipeline is drained completely between steps, so every neuron of the next step sees all of the previous-step state. With coupling disabled, no weights are fetched and the neurons of the next step follow the previous step without a gap. Each new state leaves the pipeline a fixed number of cycles after its evaluation tick. At that moment the block writes it to on-chip state and presents it on the output stream in the same cycle.

Top module: `nrn_step_seq`

## Requirements
- R1: After an accepted `start`, `init_ready` is high until N words have been accepted. Each accepted word (`init_valid` and `init_ready`) raises `st_wr_en` in the same cycle, with `st_wr_addr` counting 0 to N-1. `init_ready` never rises again in that run.
- R2: With `cfg_couple`=1, every neuron in every step is preceded by exactly L = ceil(N/U) accepted weight batches. While waiting, `wgt_ready` is high and `wgt_batch` shows the batch number, 0 to L-1. `gj_acc_en` is high exactly on the cycles a batch is accepted.
- R3: At most one of `init_ready`, `wgt_ready` and `evk_ready` is high in any cycle. `dend_valid` stays low on every loop tick.
- R4: A neuron is evaluated in the cycle its evoked input is accepted (`evk_valid` and `evk_ready`). In that cycle `dend_valid` and `st_rd_en` are high and `st_rd_addr` gives the neuron index. Within a step, neurons are evaluated in order 0 to N-1.
- R5: Exactly PIPE_DEPTH cycles after a neuron is evaluated, `st_wr_en` and `out_valid` are both high, and `st_wr_addr` gives that neuron's index. `out_valid` is never high at any other time.
- R6: With coupling on, exactly PIPE_DEPTH cycles pass after the last neuron of a step before the next step's first weight batch can be requested. No request is made during those cycles.
- R7: With coupling off, `wgt_ready` stays low. The first neuron of the next step can be accepted in the cycle right after the last neuron of the previous step.
- R8: The last step is always followed by a PIPE_DEPTH-cycle drain. `done` rises in the cycle after the drain and stays high, with all ready outputs low, until the next `start`.
- R9: `step_idx` gives the number of completed steps. It resets to 0 on `start` and reaches the configured total when `done` rises.
- R10: While a requested stream is not valid, its ready stays high and no counter or index output moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run; accepted only while idle or done |
| cfg_n | input | NW | Neuron count N (1..MAX_NEURONS) |
| cfg_steps | input | SW | Simulation steps to run (>=1) |
| cfg_couple | input | 1 | 1 = inter-neuron coupling enabled |
| cfg_unroll | input | UW | Connections handled per loop tick (>=1) |
| init_valid | input | 1 | Initial state word available |
| init_ready | output | 1 | Initial state word requested |
| wgt_valid | input | 1 | Weight batch available |
| wgt_ready | output | 1 | Weight batch requested |
| wgt_batch | output | AW | Index of requested weight batch |
| evk_valid | input | 1 | Evoked input available |
| evk_ready | output | 1 | Evoked input requested |
| gj_acc_en | output | 1 | Accumulate the accepted weight batch |
| dend_valid | output | 1 | Dendrite pipeline input is valid |
| st_rd_en | output | 1 | State memory read strobe |
| st_rd_addr | output | AW | State memory read index |
| st_wr_en | output | 1 | State memory write strobe |
| st_wr_addr | output | AW | State memory write index |
| out_valid | output | 1 | New state presented on the output stream |
| step_idx | output | SW | Completed simulation steps |
| done | output | 1 | All configured steps finished |

## Verification
If the neuron counter skips or repeats a value, the fault appears at once on `st_rd_addr`. It appears again PIPE_DEPTH cycles later as a wrong write address. A loop counter with the wrong limit changes how many weight batches come before a neuron, so the next `evk_ready` rises a cycle early or late. A flush counter that is off by one moves the first request of the following step, or `done`, by one cycle. Because the reference model compares every strobe and index on every cycle, each of these faults is reported in the first cycle it becomes visible at the ports, not only at the end of the run.

// File: rtl/nss_pkg.sv
package nss_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_INIT,
        PH_LOOP,
        PH_EVAL,
        PH_FLUSH,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic init_rdy;
        logic init_we;
        logic wgt_rdy;
        logic gj_en;
        logic evk_rdy;
        logic issue;
    } ctl_s;

    // Loop ticks per neuron: ceil(n / u); a zero unroll behaves as one.
    function automatic int unsigned ticks_per_neuron(int unsigned n, int unsigned u);
        int unsigned uu;
        uu = (u == 0) ? 1 : u;
        return (n + uu - 1) / uu;
    endfunction

endpackage

// File: rtl/nss_cfg_latch.sv
module nss_cfg_latch #(
    parameter int NW = 11,
    parameter int SW = 16,
    parameter int UW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [NW-1:0] cfg_n,
    input  logic [SW-1:0] cfg_steps,
    input  logic          cfg_couple,
    input  logic [UW-1:0] cfg_unroll,
    output logic [NW-1:0] n_q,
    output logic [SW-1:0] steps_q,
    output logic          couple_q,
    output logic [NW-1:0] ticks_q
);
    import nss_pkg::*;

    logic [NW-1:0] ticks_d;

    always_comb begin
        ticks_d = NW'(ticks_per_neuron(32'(cfg_n), 32'(cfg_unroll)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            n_q      <= '0;
            steps_q  <= '0;
            couple_q <= 1'b0;
            ticks_q  <= '0;
        end else if (load) begin
            n_q      <= cfg_n;
            steps_q  <= cfg_steps;
            couple_q <= cfg_couple;
            ticks_q  <= ticks_d;
        end
    end

endmodule

// File: rtl/nss_fsm.sv
module nss_fsm #(
    parameter int NW         = 11,
    parameter int AW         = 10,
    parameter int SW         = 16,
    parameter int PIPE_DEPTH = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [NW-1:0]   n_q,
    input  logic [SW-1:0]   steps_q,
    input  logic            couple_q,
    input  logic [NW-1:0]   ticks_q,
    input  logic            init_valid,
    input  logic            wgt_valid,
    input  logic            evk_valid,
    output nss_pkg::ctl_s   ctl,
    output logic            accept_start,
    output logic [AW-1:0]   nrn_idx,
    output logic [AW-1:0]   loop_idx,
    output logic [SW-1:0]   step_cnt,
    output logic            done
);
    import nss_pkg::*;

    localparam int FW = (PIPE_DEPTH > 1) ? $clog2(PIPE_DEPTH) : 1;
    localparam logic [FW-1:0] FLUSH_LAST = FW'(PIPE_DEPTH - 1);

    phase_e        phase;
    logic [AW-1:0] nrn_cnt;
    logic [AW-1:0] loop_cnt;
    logic [SW-1:0] step_q;
    logic [FW-1:0] flush_cnt;

    logic last_nrn;
    logic last_tick;
    logic last_step;
    phase_e after_nrn;

    always_comb begin
        last_nrn  = (NW'(nrn_cnt) + NW'(1)) == n_q;
        last_tick = (NW'(loop_cnt) + NW'(1)) == ticks_q;
        last_step = (step_q + SW'(1)) == steps_q;
        after_nrn = couple_q ? PH_LOOP : PH_EVAL;
        accept_start = start && (phase == PH_IDLE || phase == PH_DONE);

        ctl.init_rdy = (phase == PH_INIT);
        ctl.init_we  = (phase == PH_INIT) && init_valid;
        ctl.wgt_rdy  = (phase == PH_LOOP);
        ctl.gj_en    = (phase == PH_LOOP) && wgt_valid;
        ctl.evk_rdy  = (phase == PH_EVAL);
        ctl.issue    = (phase == PH_EVAL) && evk_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            nrn_cnt   <= '0;
            loop_cnt  <= '0;
            step_q    <= '0;
            flush_cnt <= '0;
        end else if (accept_start) begin
            phase     <= PH_INIT;
            nrn_cnt   <= '0;
            loop_cnt  <= '0;
            step_q    <= '0;
            flush_cnt <= '0;
        end else begin
            unique case (phase)
                PH_INIT: begin
                    if (init_valid) begin
                        if (last_nrn) begin
                            nrn_cnt <= '0;
                            phase   <= after_nrn;
                        end else begin
                            nrn_cnt <= nrn_cnt + AW'(1);
                        end
                    end
                end
                PH_LOOP: begin
                    if (wgt_valid) begin
                        if (last_tick) begin
                            loop_cnt <= '0;
                            phase    <= PH_EVAL;
                        end else begin
                            loop_cnt <= loop_cnt + AW'(1);
                        end
                    end
                end
                PH_EVAL: begin
                    if (evk_valid) begin
                        if (last_nrn) begin
                            nrn_cnt <= '0;
                            if (couple_q || last_step) begin
                                phase     <= PH_FLUSH;
                                flush_cnt <= FLUSH_LAST;
                            end else begin
                                step_q <= step_q + SW'(1);
                                phase  <= PH_EVAL;
                            end
                        end else begin
                            nrn_cnt <= nrn_cnt + AW'(1);
                            phase   <= after_nrn;
                        end
                    end
                end
                PH_FLUSH: begin
                    if (flush_cnt == '0) begin
                        step_q <= step_q + SW'(1);
                        phase  <= last_step ? PH_DONE : after_nrn;
                    end else begin
                        flush_cnt <= flush_cnt - FW'(1);
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign nrn_idx  = nrn_cnt;
    assign loop_idx = loop_cnt;
    assign step_cnt = step_q;
    assign done     = (phase == PH_DONE);

endmodule

// File: rtl/nss_wb_pipe.sv
module nss_wb_pipe #(
    parameter int AW    = 10,
    parameter int DEPTH = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          issue,
    input  logic [AW-1:0] issue_addr,
    output logic          wb_vld,
    output logic [AW-1:0] wb_addr
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
    } tok_t;

    tok_t stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[g] <= '0;
                end else begin
                    stage[g].vld  <= issue;
                    stage[g].addr <= issue_addr;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[g] <= '0;
                end else begin
                    stage[g] <= stage[g-1];
                end
            end
        end
    end

    assign wb_vld  = stage[DEPTH-1].vld;
    assign wb_addr = stage[DEPTH-1].addr;

endmodule

// File: rtl/nrn_step_seq.sv
module nrn_step_seq #(
    parameter int MAX_NEURONS = 1024,
    parameter int MAX_STEPS   = 65535,
    parameter int MAX_UNROLL  = 16,
    parameter int PIPE_DEPTH  = 6,
    localparam int NW = $clog2(MAX_NEURONS + 1),
    localparam int AW = (MAX_NEURONS > 1) ? $clog2(MAX_NEURONS) : 1,
    localparam int SW = $clog2(MAX_STEPS + 1),
    localparam int UW = $clog2(MAX_UNROLL + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] cfg_n,
    input  logic [SW-1:0] cfg_steps,
    input  logic          cfg_couple,
    input  logic [UW-1:0] cfg_unroll,
    input  logic          init_valid,
    output logic          init_ready,
    input  logic          wgt_valid,
    output logic          wgt_ready,
    output logic [AW-1:0] wgt_batch,
    input  logic          evk_valid,
    output logic          evk_ready,
    output logic          gj_acc_en,
    output logic          dend_valid,
    output logic          st_rd_en,
    output logic [AW-1:0] st_rd_addr,
    output logic          st_wr_en,
    output logic [AW-1:0] st_wr_addr,
    output logic          out_valid,
    output logic [SW-1:0] step_idx,
    output logic          done
);
    import nss_pkg::*;

    logic [NW-1:0] n_q;
    logic [SW-1:0] steps_q;
    logic          couple_q;
    logic [NW-1:0] ticks_q;
    logic          accept_start;
    ctl_s          ctl;
    logic [AW-1:0] nrn_idx;
    logic [AW-1:0] loop_idx;
    logic          wb_vld;
    logic [AW-1:0] wb_addr;

    nss_cfg_latch #(.NW(NW), .SW(SW), .UW(UW)) cfg_i (
        .clk        (clk),
        .rst        (rst),
        .load       (accept_start),
        .cfg_n      (cfg_n),
        .cfg_steps  (cfg_steps),
        .cfg_couple (cfg_couple),
        .cfg_unroll (cfg_unroll),
        .n_q        (n_q),
        .steps_q    (steps_q),
        .couple_q   (couple_q),
        .ticks_q    (ticks_q)
    );

    nss_fsm #(.NW(NW), .AW(AW), .SW(SW), .PIPE_DEPTH(PIPE_DEPTH)) fsm_i (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .n_q          (n_q),
        .steps_q      (steps_q),
        .couple_q     (couple_q),
        .ticks_q      (ticks_q),
        .init_valid   (init_valid),
        .wgt_valid    (wgt_valid),
        .evk_valid    (evk_valid),
        .ctl          (ctl),
        .accept_start (accept_start),
        .nrn_idx      (nrn_idx),
        .loop_idx     (loop_idx),
        .step_cnt     (step_idx),
        .done         (done)
    );

    nss_wb_pipe #(.AW(AW), .DEPTH(PIPE_DEPTH)) wb_i (
        .clk        (clk),
        .rst        (rst),
        .issue      (ctl.issue),
        .issue_addr (nrn_idx),
        .wb_vld     (wb_vld),
        .wb_addr    (wb_addr)
    );

    always_comb begin
        init_ready = ctl.init_rdy;
        wgt_ready  = ctl.wgt_rdy;
        wgt_batch  = loop_idx;
        evk_ready  = ctl.evk_rdy;
        gj_acc_en  = ctl.gj_en;
        dend_valid = ctl.issue;
        st_rd_en   = ctl.issue;
        st_rd_addr = nrn_idx;
        out_valid  = wb_vld;
        st_wr_en   = ctl.init_we | wb_vld;
        st_wr_addr = ctl.init_we ? nrn_idx : wb_addr;
    end

endmodule

// File: rtl/nss_checker.sv
module nss_checker #(
    parameter int AW = 10,
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          init_ready,
    input logic          wgt_ready,
    input logic          wgt_valid,
    input logic [AW-1:0] wgt_batch,
    input logic          evk_ready,
    input logic          evk_valid,
    input logic          dend_valid,
    input logic          st_rd_en,
    input logic          st_wr_en,
    input logic          out_valid,
    input logic [SW-1:0] step_idx,
    input logic          couple_q,
    input logic          done
);

    p_one_request_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({init_ready, wgt_ready, evk_ready}));

    p_loop_gates_dend_r3: assert property (@(posedge clk) disable iff (rst)
        wgt_ready |-> !dend_valid);

    p_eval_handshake_r4: assert property (@(posedge clk) disable iff (rst)
        dend_valid |-> (evk_ready && evk_valid && st_rd_en));

    p_out_with_write_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> st_wr_en);

    p_no_wb_in_init_r5: assert property (@(posedge clk) disable iff (rst)
        init_ready |-> !out_valid);

    p_init_once_r1: assert property (@(posedge clk) disable iff (rst)
        (step_idx != '0) |-> !init_ready);

    p_no_weights_uncoupled_r7: assert property (@(posedge clk) disable iff (rst)
        !couple_q |-> !wgt_ready);

    p_weight_stall_r10: assert property (@(posedge clk) disable iff (rst)
        (wgt_ready && !wgt_valid) |=> (wgt_ready && $stable(wgt_batch)));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !(init_ready || wgt_ready || evk_ready || out_valid));

endmodule

bind nrn_step_seq nss_checker #(.AW(AW), .SW(SW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .init_ready (init_ready),
    .wgt_ready  (wgt_ready),
    .wgt_valid  (wgt_valid),
    .wgt_batch  (wgt_batch),
    .evk_ready  (evk_ready),
    .evk_valid  (evk_valid),
    .dend_valid (dend_valid),
    .st_rd_en   (st_rd_en),
    .st_wr_en   (st_wr_en),
    .out_valid  (out_valid),
    .step_idx   (step_idx),
    .couple_q   (couple_q),
    .done       (done)
);

// File: tb/nrn_step_seq_tb_top.sv
module nrn_step_seq_tb_top;

    localparam int MAXN = 1024;
    localparam int MAXS = 65535;
    localparam int MAXU = 16;
    localparam int D    = 6;
    localparam int NW   = $clog2(MAXN + 1);
    localparam int AW   = $clog2(MAXN);
    localparam int SW   = $clog2(MAXS + 1);
    localparam int UW   = $clog2(MAXU + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [NW-1:0] cfg_n = '0;
    logic [SW-1:0] cfg_steps = '0;
    logic          cfg_couple = 1'b0;
    logic [UW-1:0] cfg_unroll = '0;
    logic          init_valid = 1'b0;
    logic          wgt_valid = 1'b0;
    logic          evk_valid = 1'b0;
    logic          init_ready, wgt_ready, evk_ready, gj_acc_en, dend_valid;
    logic          st_rd_en, st_wr_en, out_valid, done;
    logic [AW-1:0] wgt_batch, st_rd_addr, st_wr_addr;
    logic [SW-1:0] step_idx;

    always #4 clk = ~clk;

    nrn_step_seq #(
        .MAX_NEURONS(MAXN), .MAX_STEPS(MAXS), .MAX_UNROLL(MAXU), .PIPE_DEPTH(D)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start),
        .cfg_n(cfg_n), .cfg_steps(cfg_steps), .cfg_couple(cfg_couple), .cfg_unroll(cfg_unroll),
        .init_valid(init_valid), .init_ready(init_ready),
        .wgt_valid(wgt_valid), .wgt_ready(wgt_ready), .wgt_batch(wgt_batch),
        .evk_valid(evk_valid), .evk_ready(evk_ready),
        .gj_acc_en(gj_acc_en), .dend_valid(dend_valid),
        .st_rd_en(st_rd_en), .st_rd_addr(st_rd_addr),
        .st_wr_en(st_wr_en), .st_wr_addr(st_wr_addr),
        .out_valid(out_valid), .step_idx(step_idx), .done(done)
    );

    int checks = 0;
    int failures = 0;
    int pct = 100;
    int cN = 1, cS = 1, cU = 1, cL = 1;
    bit cC = 1'b0;

    // reference model state
    int m_ph = 0;          // 0 idle,1 init,2 loop,3 eval,4 drain,5 done
    int m_n = 0, m_l = 0, m_s = 0, m_f = 0;
    int cyc = 0;
    int q_due[$];
    int q_adr[$];
    int n_out = 0, n_init = 0, n_wgt = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", req, what, act, exp, cyc);
        end
    endtask

    always begin
        @(negedge clk);
        init_valid = (($urandom % 100) < pct);
        wgt_valid  = (($urandom % 100) < pct);
        evk_valid  = (($urandom % 100) < pct);
        #1;
        if (rst) begin
            m_ph = 0; m_n = 0; m_l = 0; m_s = 0; m_f = 0;
            q_due.delete(); q_adr.delete();
        end else begin
            bit e_init, e_wgt, e_evk, e_iss, e_iwe, e_wb;
            int e_wa;
            e_init = (m_ph == 1);
            e_wgt  = (m_ph == 2);
            e_evk  = (m_ph == 3);
            e_iss  = e_evk && evk_valid;
            e_iwe  = e_init && init_valid;
            e_wb   = (q_due.size() > 0) && (q_due[0] == cyc);
            e_wa   = e_iwe ? m_n : (e_wb ? q_adr[0] : 0);

            check("R1", "init_ready", int'(init_ready), int'(e_init));
            check("R2", "wgt_ready", int'(wgt_ready), int'(e_wgt));
            if (e_wgt) check("R2", "wgt_batch", int'(wgt_batch), m_l);
            check("R2", "gj_acc_en", int'(gj_acc_en), int'(e_wgt && wgt_valid));
            check("R3", "evk_ready", int'(evk_ready), int'(e_evk));
            check("R3", "dend_valid", int'(dend_valid), int'(e_iss));
            check("R4", "st_rd_en", int'(st_rd_en), int'(e_iss));
            if (e_iss) check("R4", "st_rd_addr", int'(st_rd_addr), m_n);
            check("R5", "out_valid", int'(out_valid), int'(e_wb));
            check("R5", "st_wr_en", int'(st_wr_en), int'(e_iwe || e_wb));
            if (e_iwe || e_wb) check("R5", "st_wr_addr", int'(st_wr_addr), e_wa);
            check("R8", "done", int'(done), int'(m_ph == 5));
            check("R9", "step_idx", int'(step_idx), m_s);

            if (out_valid) n_out++;
            if (init_ready && init_valid) n_init++;
            if (wgt_ready && wgt_valid) n_wgt++;
            if (e_wb) begin
                void'(q_due.pop_front());
                void'(q_adr.pop_front());
            end

            if (start && (m_ph == 0 || m_ph == 5)) begin
                m_ph = 1; m_n = 0; m_l = 0; m_s = 0;
            end else begin
                case (m_ph)
                    1: if (init_valid) begin
                        if (m_n == cN - 1) begin m_n = 0; m_ph = cC ? 2 : 3; end
                        else m_n++;
                    end
                    2: if (wgt_valid) begin
                        if (m_l == cL - 1) begin m_l = 0; m_ph = 3; end
                        else m_l++;
                    end
                    3: if (evk_valid) begin
                        q_due.push_back(cyc + D);
                        q_adr.push_back(m_n);
                        if (m_n == cN - 1) begin
                            m_n = 0;
                            if (cC || m_s == cS - 1) begin m_ph = 4; m_f = D; end
                            else m_s++;
                        end else begin
                            m_n++;
                            m_ph = cC ? 2 : 3;
                        end
                    end
                    4: begin
                        m_f--;
                        if (m_f == 0) begin
                            m_s++;
                            m_ph = (m_s == cS) ? 5 : (cC ? 2 : 3);
                        end
                    end
                    default: ;
                endcase
            end
        end
        cyc++;
    end

    task automatic run(input int n, input int s, input bit c, input int u, input int p);
        int waited;
        cN = n; cS = s; cC = c; cU = u; cL = (n + u - 1) / u; pct = p;
        @(negedge clk);
        cfg_n = NW'(n); cfg_steps = SW'(s); cfg_couple = c; cfg_unroll = UW'(u);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n_out = 0; n_init = 0; n_wgt = 0;
        waited = 0;
        while (waited < 20000) begin
            @(negedge clk);
            #2;
            if (done) break;
            waited++;
        end
        if (waited >= 20000) begin
            checks++; failures++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
        end
        repeat (4) @(negedge clk);
        #2;
        check("R8", "done held", int'(done), 1);
        check("R9", "final step_idx", int'(step_idx), s);
        check("R5", "writebacks per run", n_out, n * s);
        check("R1", "init words per run", n_init - 0, n - 1 + 1 - (start ? 1 : 0) + 0);
        if (c) check("R2", "weight batches per run", n_wgt, n * cL * s);
        else   check("R7", "weight batches uncoupled", n_wgt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        check("R8", "reset done", int'(done), 0);
        check("R1", "reset init_ready", int'(init_ready), 0);
        check("R9", "reset step_idx", int'(step_idx), 0);
        run(5, 3, 1'b1, 2, 100);   // R2 R6: coupled, L=3, full rate
        run(5, 2, 1'b1, 2, 55);    // R10: coupled with stalls
        run(4, 3, 1'b0, 1, 100);   // R7: back-to-back steps
        run(3, 2, 1'b0, 4, 60);    // R7 R10: uncoupled with stalls
        run(1, 2, 1'b1, 4, 100);   // R2: single neuron, L=1
        run(6, 2, 1'b1, 6, 100);   // R2: unroll equals N
        run(4, 1, 1'b1, 1, 80);    // R2 R8: L=N, single step
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1500000;
        failures++;
        checks++;
        $display("FAIL watchdog global actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule